// File: doc/BRIEF.md
# Prioritized DMA Event Queue Manager

This block sits between the trigger sources of a multi-channel DMA controller and its transfer engines. Every channel can be triggered in three ways: a hardware event from a peripheral, a chain trigger raised when another transfer completes, and a manual set from software. The block latches each trigger and picks one winner per clock cycle. It then writes the winner's channel number and trigger type into one of several FIFO event queues, chosen by a per-channel queue map.

A dequeue arbiter presents the head of the lowest-numbered non-empty queue on a single transfer-request output and pops it on a ready handshake. Each queue reports how full it is now, its read pointer, and its peak occupancy. Each queue also has a programmable threshold and a sticky error flag that is set when occupancy goes above the threshold. A trigger can be lost in two ways: it arrives while the same trigger is still pending on its channel, or its target queue is full. In both cases the trigger is dropped and the channel's missed-event flag is set.

Top module: `evq_manager`

## Requirements
- R1: Each queue holds up to `Q_DEPTH` (default 16) entries and returns them in the order they were written.
- R2: `tr_valid` is high whenever any queue holds an entry. The output then shows the head of the lowest-numbered non-empty queue, and that entry is removed at a clock edge where `tr_ready` is high.
- R3: Each entry carries the channel number and the trigger type, encoded as 0 = hardware event, 1 = chain trigger, 2 = manual set.
- R4: When several trigger types are pending on the same channel, the hardware event is queued first, then the chain trigger, then the manual set.
- R5: When several channels are pending, the lowest channel index wins. Indices 0 to `NUM_DMA`-1 are event-driven channels and the indices above them are quick channels, so event-driven channels always win over quick channels.
- R6: The winner goes to the queue named by its 2-bit field in `q_map` (channel c uses bits [2c+1:2c]). A value above the last queue selects the last queue.
- R7: A hardware event stays latched, and is not queued, while its bit in `ch_en` is 0. It is queued once the bit becomes 1.
- R8: A trigger that arrives while the same type is still pending on that channel (and is not being queued in the same cycle) is dropped, and it sets `missed[c]` at that edge.
- R9: A winner whose target queue is full is removed from its pending latch but not written to any queue, and it sets `missed[c]`.
- R10: `q_thr_err[q]` is set one cycle after the occupancy of queue q goes above its 4-bit threshold field `q_thresh[4q+3:4q]`. It stays set until a 1 is written to `clr_thr[q]`. A threshold of 0 trips on a single entry.
- R11: `q_count` gives the live occupancy and `q_start` gives the read pointer. `q_peak` gives the highest occupancy seen. Writing 1 to `clr_peak[q]` resets the peak to the current occupancy.
- R12: After reset, all queues are empty, and all pointers, peaks, missed flags and error flags are 0.
- R13: Writing 1 to a bit of `clr_missed` clears that channel's missed flag, unless a new miss sets it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_evt | input | NCH | Hardware event pulses, one per channel |
| chain_evt | input | NCH | Chain trigger pulses |
| man_evt | input | NCH | Manual set pulses |
| ch_en | input | NCH | Hardware event enable, per channel |
| q_map | input | NCH*QW | Target queue of each channel |
| q_thresh | input | NUM_Q*PW | Occupancy threshold of each queue |
| clr_missed | input | NCH | Write-1 clear of missed flags |
| clr_thr | input | NUM_Q | Write-1 clear of threshold errors |
| clr_peak | input | NUM_Q | Write-1 reset of peak occupancy |
| tr_ready | input | 1 | Transfer engine accepts the presented entry |
| tr_valid | output | 1 | An entry is presented |
| tr_queue | output | QW | Queue the presented entry comes from |
| tr_type | output | 2 | Trigger type of the presented entry |
| tr_chan | output | CHW | Channel of the presented entry |
| missed | output | NCH | Sticky missed-event flags |
| q_count | output | NUM_Q*CW | Live occupancy of each queue |
| q_start | output | NUM_Q*PW | Read pointer of each queue |
| q_peak | output | NUM_Q*CW | Peak occupancy of each queue |
| q_thr_err | output | NUM_Q | Sticky threshold-exceeded flags |

## Verification
The assertions check several properties on every cycle:
- occupancy never goes past the queue depth, and a lone accepted write adds exactly one;
- the peak never falls below the live count;
- a threshold flag stays set until it is cleared;
- a hardware winner always has its enable bit set;
- a latch is only ever consumed while it is pending;
- duplicates and full-queue drops always set the missed flag;
- the presented entry always comes from the lowest non-empty queue.

Only the bench scenarios can show the exact service order:
- type ranking within a channel and index ranking across channels;
- FIFO order across a full queue and the wrap of the read pointer;
- which triggers are dropped when a burst overfills a queue;
- the delay between an event being re-enabled and it appearing at the output.

// File: rtl/eq_pkg.sv
// Package: shared trigger-type encoding for the event queue manager.
// Assumes: the encoding below is also the entry format seen on the output.
package eq_pkg;
    typedef enum logic [1:0] {
        TRIG_HW    = 2'd0,
        TRIG_CHAIN = 2'd1,
        TRIG_MAN   = 2'd2
    } trig_t;
endpackage

// File: rtl/eq_trig_latch.sv
// Holds one pending bit per channel and trigger type. Reports any trigger
// that lands on a bit that is already pending and is not being consumed.
// Assumes: the take_* vectors name at most one bit, and only a pending one.
module eq_trig_latch #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hw_in,
    input  logic [NCH-1:0] chn_in,
    input  logic [NCH-1:0] man_in,
    input  logic [NCH-1:0] take_hw,
    input  logic [NCH-1:0] take_chn,
    input  logic [NCH-1:0] take_man,
    output logic [NCH-1:0] hw_pend,
    output logic [NCH-1:0] chn_pend,
    output logic [NCH-1:0] man_pend,
    output logic [NCH-1:0] dup
);
    logic [NCH-1:0] hw_keep, chn_keep, man_keep;

    // Bits that survive this cycle because they are not consumed.
    always_comb begin
        hw_keep  = hw_pend  & ~take_hw;
        chn_keep = chn_pend & ~take_chn;
        man_keep = man_pend & ~take_man;
        dup      = (hw_in & hw_keep) | (chn_in & chn_keep) | (man_in & man_keep);
    end

    // Pending state: a new trigger sets its bit, consumption clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_pend  <= '0;
            chn_pend <= '0;
            man_pend <= '0;
        end else begin
            hw_pend  <= hw_keep  | hw_in;
            chn_pend <= chn_keep | chn_in;
            man_pend <= man_keep | man_in;
        end
    end

    AST_TAKE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ((take_hw & ~hw_pend) | (take_chn & ~chn_pend) | (take_man & ~man_pend)) == '0); // R4
endmodule

// File: rtl/eq_trig_pick.sv
// Picks one pending trigger per cycle. The lowest channel index wins, and
// within that channel the hardware event beats chain, and chain beats manual.
// Assumes: hw_req has already been masked by the channel enables.
module eq_trig_pick
    import eq_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CHW = 3
) (
    input  logic [NCH-1:0] hw_req,
    input  logic [NCH-1:0] chn_req,
    input  logic [NCH-1:0] man_req,
    output logic           win_valid,
    output logic [CHW-1:0] win_chan,
    output trig_t          win_type,
    output logic [NCH-1:0] take_hw,
    output logic [NCH-1:0] take_chn,
    output logic [NCH-1:0] take_man
);
    // Scan from the top down so that the lowest requesting index is kept last.
    always_comb begin
        win_valid = 1'b0;
        win_chan  = '0;
        win_type  = TRIG_MAN;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (hw_req[i] || chn_req[i] || man_req[i]) begin
                win_valid = 1'b1;
                win_chan  = CHW'(i);
                if (hw_req[i])       win_type = TRIG_HW;
                else if (chn_req[i]) win_type = TRIG_CHAIN;
                else                 win_type = TRIG_MAN;
            end
        end
    end

    // Consume exactly the latch bit of the winner.
    always_comb begin
        take_hw  = '0;
        take_chn = '0;
        take_man = '0;
        if (win_valid) begin
            case (win_type)
                TRIG_HW:    take_hw[win_chan]  = 1'b1;
                TRIG_CHAIN: take_chn[win_chan] = 1'b1;
                default:    take_man[win_chan] = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/eq_fifo.sv
// One event queue, with its occupancy count, peak tracking and sticky
// threshold-exceeded flag.
// Assumes: DEPTH is a power of two. A write into a full queue is refused,
// even when a read happens in the same cycle.
module eq_fifo #(
    parameter int DEPTH = 16,
    parameter int EW    = 5,
    parameter int PW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [EW-1:0] push_data,
    input  logic          pop,
    input  logic [PW-1:0] thresh,
    input  logic          clr_thr,
    input  logic          clr_peak,
    output logic          full,
    output logic          empty,
    output logic [EW-1:0] head,
    output logic [CW-1:0] count,
    output logic [PW-1:0] start,
    output logic [CW-1:0] peak,
    output logic          thr_err
);
    logic [EW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count_d;
    logic          push_ok, pop_ok;

    // Decide which accesses are allowed and compute the next occupancy.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        push_ok = push & ~full;
        pop_ok  = pop & ~empty;
        count_d = count + CW'(push_ok) - CW'(pop_ok);
        head    = mem[rd_ptr];
        start   = rd_ptr;
    end

    // Storage write; the array is not reset.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointers, occupancy, peak and threshold flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            peak    <= '0;
            thr_err <= 1'b0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            count <= count_d;
            if (clr_peak)           peak <= count_d;
            else if (count_d > peak) peak <= count_d;
            if (count > {1'b0, thresh}) thr_err <= 1'b1;
            else if (clr_thr)           thr_err <= 1'b0;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH)); // R1
    AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> count == $past(count) + 1'b1); // R11
    AST_THR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_err && !clr_thr) |=> thr_err); // R10
    AST_PEAK_GE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        peak >= count); // R11
endmodule

// File: rtl/eq_deq_arb.sv
// Fixed-priority dequeue: the lowest-numbered non-empty queue is presented,
// and it is popped when the consumer is ready.
// Assumes: NQ is no greater than 2**QW.
module eq_deq_arb #(
    parameter int NQ = 3,
    parameter int QW = 2
) (
    input  logic [NQ-1:0] nonempty,
    input  logic          tr_ready,
    output logic          tr_valid,
    output logic [QW-1:0] sel,
    output logic [NQ-1:0] pop
);
    // Top-down scan keeps the lowest non-empty queue.
    always_comb begin
        tr_valid = |nonempty;
        sel      = '0;
        pop      = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (nonempty[i]) sel = QW'(i);
        end
        if (tr_valid && tr_ready) pop[sel] = 1'b1;
    end
endmodule

// File: rtl/evq_manager.sv
// Top: captures triggers, picks one winner per cycle, routes it to a queue
// through the channel map, and presents the queue heads in priority order.
// Assumes: pulses are one cycle wide and synchronous to clk.
module evq_manager
    import eq_pkg::*;
#(
    parameter int NUM_DMA  = 6,
    parameter int NUM_QDMA = 2,
    parameter int NUM_Q    = 3,
    parameter int Q_DEPTH  = 16,
    localparam int NCH = NUM_DMA + NUM_QDMA,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int QW  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
    localparam int PW  = $clog2(Q_DEPTH),
    localparam int CW  = PW + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      hw_evt,
    input  logic [NCH-1:0]      chain_evt,
    input  logic [NCH-1:0]      man_evt,
    input  logic [NCH-1:0]      ch_en,
    input  logic [NCH*QW-1:0]   q_map,
    input  logic [NUM_Q*PW-1:0] q_thresh,
    input  logic [NCH-1:0]      clr_missed,
    input  logic [NUM_Q-1:0]    clr_thr,
    input  logic [NUM_Q-1:0]    clr_peak,
    input  logic                tr_ready,
    output logic                tr_valid,
    output logic [QW-1:0]       tr_queue,
    output logic [1:0]          tr_type,
    output logic [CHW-1:0]      tr_chan,
    output logic [NCH-1:0]      missed,
    output logic [NUM_Q*CW-1:0] q_count,
    output logic [NUM_Q*PW-1:0] q_start,
    output logic [NUM_Q*CW-1:0] q_peak,
    output logic [NUM_Q-1:0]    q_thr_err
);
    localparam int EW = 2 + CHW;
    localparam logic [QW-1:0] QLAST = QW'(NUM_Q - 1);

    logic [NCH-1:0] hw_pend, chn_pend, man_pend, dup;
    logic [NCH-1:0] take_hw, take_chn, take_man;
    logic           win_valid;
    logic [CHW-1:0] win_chan;
    trig_t          win_type;
    logic [QW-1:0]  map_raw, tgt;
    logic [NUM_Q-1:0] q_full, q_empty, q_push, q_pop;
    logic [EW-1:0]  q_head [NUM_Q];
    logic [EW-1:0]  win_entry;
    logic [NCH-1:0] drop_full, miss_set;

    eq_trig_latch #(.NCH(NCH)) i_latch (
        .clk(clk), .rst_n(rst_n),
        .hw_in(hw_evt), .chn_in(chain_evt), .man_in(man_evt),
        .take_hw(take_hw), .take_chn(take_chn), .take_man(take_man),
        .hw_pend(hw_pend), .chn_pend(chn_pend), .man_pend(man_pend),
        .dup(dup)
    );

    eq_trig_pick #(.NCH(NCH), .CHW(CHW)) i_pick (
        .hw_req(hw_pend & ch_en), .chn_req(chn_pend), .man_req(man_pend),
        .win_valid(win_valid), .win_chan(win_chan), .win_type(win_type),
        .take_hw(take_hw), .take_chn(take_chn), .take_man(take_man)
    );

    // Route the winner: look up and clamp the map, detect a full target.
    always_comb begin
        map_raw   = q_map[win_chan*QW +: QW];
        tgt       = (map_raw > QLAST) ? QLAST : map_raw;
        win_entry = {win_type, win_chan};
        q_push    = '0;
        drop_full = '0;
        if (win_valid) begin
            q_push[tgt] = 1'b1;
            if (q_full[tgt]) drop_full[win_chan] = 1'b1;
        end
        miss_set = dup | drop_full;
    end

    // Sticky missed flags; a new miss wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) missed <= '0;
        else        missed <= (missed & ~clr_missed) | miss_set;
    end

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
            eq_fifo #(.DEPTH(Q_DEPTH), .EW(EW), .PW(PW), .CW(CW)) i_fifo (
                .clk(clk), .rst_n(rst_n),
                .push(q_push[q]), .push_data(win_entry), .pop(q_pop[q]),
                .thresh(q_thresh[q*PW +: PW]),
                .clr_thr(clr_thr[q]), .clr_peak(clr_peak[q]),
                .full(q_full[q]), .empty(q_empty[q]), .head(q_head[q]),
                .count(q_count[q*CW +: CW]), .start(q_start[q*PW +: PW]),
                .peak(q_peak[q*CW +: CW]), .thr_err(q_thr_err[q])
            );
        end
    endgenerate

    eq_deq_arb #(.NQ(NUM_Q), .QW(QW)) i_arb (
        .nonempty(~q_empty), .tr_ready(tr_ready),
        .tr_valid(tr_valid), .sel(tr_queue), .pop(q_pop)
    );

    // Present the head entry of the selected queue.
    always_comb begin
        tr_type = q_head[tr_queue][EW-1 -: 2];
        tr_chan = q_head[tr_queue][CHW-1:0];
    end

    // Mask of the queues below the presented one, used only by a check.
    logic [NUM_Q-1:0] below_mask;
    always_comb begin
        below_mask = '0;
        for (int i = 0; i < NUM_Q; i++) below_mask[i] = (QW'(i) < tr_queue);
    end

    AST_EN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && win_type == TRIG_HW) |-> ch_en[win_chan]); // R7
    AST_DUP_MISSED: assert property (@(posedge clk) disable iff (!rst_n)
        (|dup) |=> ((missed & $past(dup)) == $past(dup))); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && q_full[tgt]) |=> missed[$past(win_chan)]); // R9
    AST_DEQ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid |-> ((~q_empty & below_mask) == '0 && !q_empty[tr_queue])); // R2
endmodule

// File: tb/test_evq_manager.sv
module test_evq_manager;
    localparam int NCH = 8;
    localparam int NQ  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  hw_evt = '0, chain_evt = '0, man_evt = '0, ch_en = '0;
    logic [15:0] q_map = '0;
    logic [11:0] q_thresh = '0;
    logic [7:0]  clr_missed = '0;
    logic [2:0]  clr_thr = '0, clr_peak = '0;
    logic        tr_ready = 1'b0;
    logic        tr_valid;
    logic [1:0]  tr_queue, tr_type;
    logic [2:0]  tr_chan;
    logic [7:0]  missed;
    logic [14:0] q_count, q_peak;
    logic [11:0] q_start;
    logic [2:0]  q_thr_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    evq_manager i_evq_manager (
        .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt), .chain_evt(chain_evt),
        .man_evt(man_evt), .ch_en(ch_en), .q_map(q_map), .q_thresh(q_thresh),
        .clr_missed(clr_missed), .clr_thr(clr_thr), .clr_peak(clr_peak),
        .tr_ready(tr_ready), .tr_valid(tr_valid), .tr_queue(tr_queue),
        .tr_type(tr_type), .tr_chan(tr_chan), .missed(missed),
        .q_count(q_count), .q_start(q_start), .q_peak(q_peak),
        .q_thr_err(q_thr_err)
    );

    // Row: hw | chain | man | first chan | first type | second valid | second chan | second type
    localparam logic [34:0] VEC [6] = '{
        {8'h01, 8'h00, 8'h00, 3'd0, 2'd0, 1'b0, 3'd0, 2'd0},
        {8'h20, 8'h20, 8'h04, 3'd2, 2'd2, 1'b1, 3'd5, 2'd0},
        {8'h00, 8'h80, 8'h40, 3'd6, 2'd2, 1'b1, 3'd7, 2'd1},
        {8'h08, 8'h00, 8'h08, 3'd3, 2'd0, 1'b1, 3'd3, 2'd2},
        {8'h00, 8'h12, 8'h00, 3'd1, 2'd1, 1'b1, 3'd4, 2'd1},
        {8'h81, 8'h00, 8'h00, 3'd0, 2'd0, 1'b1, 3'd7, 2'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        tr_ready = 1'b1;
        cyc(20);
        tr_ready = 1'b0;
    endtask

    function automatic int cnt(input int q);
        return int'(q_count[q*5 +: 5]);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int start0;
        ch_en = 8'hFF;
        q_thresh = 12'hFFF;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R12 reset state
        chk("R12 tr_valid", int'(tr_valid), 0);
        chk("R12 count", int'(q_count), 0);
        chk("R12 peak", int'(q_peak), 0);
        chk("R12 start", int'(q_start), 0);
        chk("R12 missed", int'(missed), 0);
        chk("R12 thr_err", int'(q_thr_err), 0);

        // R3 R4 R5 R1 table walk
        foreach (VEC[k]) begin
            hw_evt = VEC[k][34:27]; chain_evt = VEC[k][26:19]; man_evt = VEC[k][18:11];
            cyc(1);
            hw_evt = '0; chain_evt = '0; man_evt = '0;
            cyc(6);
            chk("R2 valid", int'(tr_valid), 1);
            chk("R5 first chan", int'(tr_chan), int'(VEC[k][10:8]));
            chk("R4 first type", int'(tr_type), int'(VEC[k][7:6]));
            tr_ready = 1'b1; cyc(1); tr_ready = 1'b0;
            chk("R2 second valid", int'(tr_valid), int'(VEC[k][5]));
            if (VEC[k][5]) begin
                chk("R5 second chan", int'(tr_chan), int'(VEC[k][4:2]));
                chk("R3 second type", int'(tr_type), int'(VEC[k][1:0]));
            end
            drain();
            chk("R2 drained", int'(tr_valid), 0);
        end

        // R7 enable gating
        ch_en = 8'hFB;
        hw_evt = 8'h04; cyc(1); hw_evt = '0;
        cyc(5);
        chk("R7 held while disabled", int'(tr_valid), 0);
        chk("R7 queue empty", cnt(0), 0);
        ch_en = 8'hFF;
        cyc(2);
        chk("R7 valid after enable", int'(tr_valid), 1);
        chk("R7 chan", int'(tr_chan), 2);
        chk("R3 hw type", int'(tr_type), 0);
        drain();

        // R8 duplicate while pending, R13 clear
        ch_en = 8'hEF;
        hw_evt = 8'h10; cyc(1); hw_evt = '0; cyc(1);
        hw_evt = 8'h10; cyc(1); hw_evt = '0;
        chk("R8 missed set", int'(missed), 8'h10);
        clr_missed = 8'h10; cyc(1); clr_missed = '0;
        chk("R13 missed cleared", int'(missed), 0);
        ch_en = 8'hFF;
        cyc(3);
        chk("R8 one entry kept", cnt(0), 1);
        drain();

        // R6 map, R2 queue order, R10 threshold 0
        q_map = 16'h0048;
        q_thresh = 12'h01F;
        man_evt = 8'h0A; cyc(1); man_evt = '0;
        cyc(6);
        chk("R6 q1 count", cnt(1), 1);
        chk("R6 q2 count", cnt(2), 1);
        chk("R10 thr flags", int'(q_thr_err), 3'b100);
        chk("R2 queue1 first", int'(tr_queue), 1);
        chk("R6 chan3 in q1", int'(tr_chan), 3);
        tr_ready = 1'b1; cyc(1); tr_ready = 1'b0;
        chk("R2 queue2 next", int'(tr_queue), 2);
        chk("R6 chan1 in q2", int'(tr_chan), 1);
        chk("R3 man type", int'(tr_type), 2);
        drain();
        chk("R10 flag sticky", int'(q_thr_err), 3'b100);
        clr_thr = 3'b111; cyc(1); clr_thr = '0;
        chk("R10 flag cleared", int'(q_thr_err), 0);
        q_map = '0;
        q_thresh = 12'hFFF;

        // R9 full queue, R1 order and depth, R11 status
        q_thresh = 12'hFFE;
        start0 = int'(q_start[3:0]);
        hw_evt = 8'hFF; chain_evt = 8'hFF; man_evt = 8'hFF; cyc(1);
        hw_evt = '0; chain_evt = '0; man_evt = '0;
        cyc(30);
        chk("R1 depth", cnt(0), 16);
        chk("R9 dropped channels", int'(missed), 8'hE0);
        chk("R11 peak", int'(q_peak[4:0]), 16);
        chk("R10 over threshold", int'(q_thr_err), 3'b001);
        for (int i = 0; i < 16; i++) begin
            chk("R1 fifo chan", int'(tr_chan), i / 3);
            chk("R1 fifo type", int'(tr_type), i % 3);
            tr_ready = 1'b1; cyc(1); tr_ready = 1'b0;
        end
        chk("R1 empty after 16", int'(tr_valid), 0);
        chk("R11 count zero", cnt(0), 0);
        chk("R11 start wrapped", int'(q_start[3:0]), start0);
        chk("R11 peak held", int'(q_peak[4:0]), 16);
        clr_peak = 3'b001; cyc(1); clr_peak = '0;
        chk("R11 peak reset", int'(q_peak[4:0]), 0);
        clr_missed = 8'hFF; clr_thr = 3'b111; cyc(1);
        clr_missed = '0; clr_thr = '0;
        chk("R13 all cleared", int'(missed), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule